// File: doc/BRIEF.md
# Debug Bus Trigger and Capture Unit

This block watches a CPU bus and decides when a debug breakpoint should be requested. On every valid bus cycle it sees the address, the data byte, the read/write direction, an instruction-fetch flag and a change-of-flow flag. Two comparators, A and B, are shared by nine trigger modes: basic, sequence, data-qualified, event and range. While it is armed, the unit records 16-bit entries into an 8-deep capture FIFO. In event modes an entry is a data value. In all other modes it is the address of a change-of-flow cycle.

When the trigger fires, the unit disarms itself, sets a sticky triggered flag and raises a breakpoint request. A force request is raised in the cycle after the matching access. A tag request is deferred until the flagged fetched opcode is reported as executed. A small write-only configuration port loads the comparators and the control word, and writing the control word with its arm bit set starts a new session. A read strobe drains the FIFO, oldest entry first.

Top module: `dbg_trig_top`

## Requirements
- R1: After reset the unit is disarmed, the triggered and overflow flags are 0, the FIFO count is 0 and brk_o is 0.
- R2: Configuration writes use cfg_addr_i 0 for comparator A's address, 1 for comparator B (its low byte is also B's data value) and 2 for the control word. A write to address 3 is ignored. The control word holds mode [3:0], tag select [4], A direction-check enable [5], A required rnw [6], B direction-check enable [7], B required rnw [8] and arm [9]. Writing the control word with arm=1 arms the unit and clears the triggered flag, the sequence state, a pending tag, the overflow flag and the FIFO. Writing it with arm=0 disarms the unit.
- R3: Mode 0 fires on an A address match. Mode 1 fires on an A or a B address match. When a direction check is enabled, the comparator matches only if bus_rnw_i equals the required value.
- R4: Mode 2 fires on a B match only if an A match was seen in an earlier cycle since arming. An A match and a B match in the same cycle does not fire.
- R5: Mode 3 fires on an A address match whose data equals B's low byte. Mode 4 fires on an A address match whose data differs from B's low byte.
- R6: Mode 7 fires when A <= address <= B, with both bounds inclusive. Mode 8 fires when the address is below A or above B. Both are qualified by A's direction check.
- R7: Mode 5 pushes the zero-extended data byte of every B match. Mode 6 does the same, but only after an earlier A match. Neither mode ever fires, and neither captures change-of-flow addresses.
- R8: In modes 0 to 4, 7 and 8, every armed valid cycle with bus_cof_i set pushes its address into the FIFO, including the cycle that fires.
- R9: The FIFO holds 8 entries. When it is full, a push is dropped and the sticky overflow flag is set. rd_i pops the oldest entry and decrements the count. rd_data_o is 0 when the FIFO is empty.
- R10: On a fire the unit disarms, sets triggered_o, and captures nothing more until it is re-armed.
- R11: With tag select 0, brk_o is high for exactly the one cycle after the firing access.
- R12: With tag select 1, only fetch cycles can fire. brk_o stays low at the fire and goes high for one cycle after the next exec_i pulse.
- R13: Mode encodings 9 to 15 never fire and never capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 8 | Bus data byte |
| bus_rnw_i | input | 1 | 1 = read, 0 = write |
| bus_fetch_i | input | 1 | Cycle is an opcode fetch |
| bus_cof_i | input | 1 | Cycle is a change-of-flow target |
| exec_i | input | 1 | Previously fetched opcode has reached execution |
| rd_i | input | 1 | FIFO pop strobe |
| rd_data_o | output | 16 | Oldest FIFO entry, 0 when empty |
| fifo_cnt_o | output | 4 | FIFO occupancy |
| armed_o | output | 1 | Unit is monitoring |
| triggered_o | output | 1 | Sticky trigger flag |
| ovf_o | output | 1 | Sticky overflow flag, set when a push is dropped |
| brk_o | output | 1 | Breakpoint request pulse |

## Verification
The bench places comparator A and comparator B on the same address to check that a sequence cannot fire on its own first match: a design that counted the same-cycle A match would fire one access early. Range tests land exactly on both bounds and one step outside them, which catches any off-by-one in the inclusive compares. Overfilling the FIFO checks that the oldest eight entries survive and that overflow is flagged; a design that overwrote entries or wrapped its count would return the wrong order or lose data. Tag tests present the matching address on a non-fetch cycle and then delay execution, so a design that raised the request at the fire, or on data accesses, shows an early brk_o.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [3:0] {
    MODE_A_ONLY   = 4'd0,
    MODE_A_OR_B   = 4'd1,
    MODE_A_THEN_B = 4'd2,
    MODE_A_DAT_EQ = 4'd3,
    MODE_A_DAT_NE = 4'd4,
    MODE_EVT_B    = 4'd5,
    MODE_A_EVT_B  = 4'd6,
    MODE_IN_RNG   = 4'd7,
    MODE_OUT_RNG  = 4'd8
  } trig_mode_e;

  typedef struct packed {
    logic rw_en;
    logic rw;
  } rw_qual_t;
endpackage

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] a_val_i,
  input  logic [AW-1:0] b_val_i,
  input  rw_qual_t      a_q_i,
  input  rw_qual_t      b_q_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          rnw_i,
  input  logic          seq_a_i,
  output logic          a_hit_o,
  output logic          fire_o,
  output logic          evt_cap_o
);
  logic a_rw_ok, b_rw_ok, b_hit, dat_eq, ge_a, le_b;

  assign a_rw_ok = !a_q_i.rw_en || (rnw_i == a_q_i.rw);
  assign b_rw_ok = !b_q_i.rw_en || (rnw_i == b_q_i.rw);
  assign a_hit_o = valid_i && a_rw_ok && (addr_i == a_val_i);
  assign b_hit   = valid_i && b_rw_ok && (addr_i == b_val_i);
  assign dat_eq  = data_i == b_val_i[DW-1:0];
  assign ge_a    = addr_i >= a_val_i;
  assign le_b    = addr_i <= b_val_i;

  always_comb begin
    fire_o    = 1'b0;
    evt_cap_o = 1'b0;
    case (mode_i)
      MODE_A_ONLY:   fire_o = a_hit_o;
      MODE_A_OR_B:   fire_o = a_hit_o || b_hit;
      MODE_A_THEN_B: fire_o = b_hit && seq_a_i;
      MODE_A_DAT_EQ: fire_o = a_hit_o && dat_eq;
      MODE_A_DAT_NE: fire_o = a_hit_o && !dat_eq;
      MODE_EVT_B:    evt_cap_o = b_hit;
      MODE_A_EVT_B:  evt_cap_o = b_hit && seq_a_i;
      MODE_IN_RNG:   fire_o = valid_i && a_rw_ok && ge_a && le_b;
      MODE_OUT_RNG:  fire_o = valid_i && a_rw_ok && (!ge_a || !le_b);
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_trig_fifo.sv
module dbg_trig_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, empty;

  assign empty   = cnt_o == '0;
  assign full_o  = cnt_o == CW'(DEPTH);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty;
  assign dout_o  = empty ? '0 : mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt_o <= cnt_o + 1'b1;
      else if (do_pop && !do_push) cnt_o <= cnt_o - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH)); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i && !clr_i) |=> full_o); // R9
endmodule

// File: rtl/dbg_trig_top.sv
module dbg_trig_top
  import dbg_trig_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [AW-1:0]   cfg_wdata_i,
  input  logic            bus_valid_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_data_i,
  input  logic            bus_rnw_i,
  input  logic            bus_fetch_i,
  input  logic            bus_cof_i,
  input  logic            exec_i,
  input  logic            rd_i,
  output logic [AW-1:0]   rd_data_o,
  output logic [CNTW-1:0] fifo_cnt_o,
  output logic            armed_o,
  output logic            triggered_o,
  output logic            ovf_o,
  output logic            brk_o
);
  localparam logic [1:0] REG_A = 2'd0, REG_B = 2'd1, REG_CTRL = 2'd2;

  logic [AW-1:0] a_val, b_val;
  logic [3:0]    mode;
  logic          tag_sel, seq_a, tag_pend;
  rw_qual_t      a_q, b_q;
  logic          a_hit, fire, evt_cap, fire_ok;
  logic          ctrl_wr, arm_wr, cof_mode, evt_mode, push_req, fifo_full;
  logic [AW-1:0] push_data;

  assign ctrl_wr  = cfg_we_i && (cfg_addr_i == REG_CTRL);
  assign arm_wr   = ctrl_wr && cfg_wdata_i[9];
  assign evt_mode = (mode == MODE_EVT_B) || (mode == MODE_A_EVT_B);
  assign cof_mode = (mode <= MODE_A_DAT_NE) || (mode == MODE_IN_RNG) || (mode == MODE_OUT_RNG);
  assign fire_ok  = fire && (!tag_sel || bus_fetch_i);

  dbg_trig_cmp #(.AW(AW), .DW(DW)) i_cmp (
    .mode_i   (mode),
    .a_val_i  (a_val),
    .b_val_i  (b_val),
    .a_q_i    (a_q),
    .b_q_i    (b_q),
    .valid_i  (bus_valid_i),
    .addr_i   (bus_addr_i),
    .data_i   (bus_data_i),
    .rnw_i    (bus_rnw_i),
    .seq_a_i  (seq_a),
    .a_hit_o  (a_hit),
    .fire_o   (fire),
    .evt_cap_o(evt_cap)
  );

  always_comb begin
    push_req  = 1'b0;
    push_data = bus_addr_i;
    if (armed_o && !ctrl_wr) begin
      if (evt_mode) begin
        push_req  = evt_cap;
        push_data = AW'(bus_data_i);
      end else if (cof_mode) begin
        push_req  = bus_valid_i && bus_cof_i;
      end
    end
  end

  dbg_trig_fifo #(.W(AW), .DEPTH(DEPTH)) i_fifo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (arm_wr),
    .push_i(push_req),
    .din_i (push_data),
    .pop_i (rd_i),
    .dout_o(rd_data_o),
    .cnt_o (fifo_cnt_o),
    .full_o(fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_val <= '0;
      b_val <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == REG_A) a_val <= cfg_wdata_i;
      if (cfg_addr_i == REG_B) b_val <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode        <= 4'hF;
      tag_sel     <= 1'b0;
      a_q         <= '0;
      b_q         <= '0;
      armed_o     <= 1'b0;
      triggered_o <= 1'b0;
      seq_a       <= 1'b0;
      tag_pend    <= 1'b0;
      ovf_o       <= 1'b0;
      brk_o       <= 1'b0;
    end else begin
      brk_o <= 1'b0;
      if (ctrl_wr) begin
        mode    <= cfg_wdata_i[3:0];
        tag_sel <= cfg_wdata_i[4];
        a_q     <= '{rw_en: cfg_wdata_i[5], rw: cfg_wdata_i[6]};
        b_q     <= '{rw_en: cfg_wdata_i[7], rw: cfg_wdata_i[8]};
        armed_o <= cfg_wdata_i[9];
        if (cfg_wdata_i[9]) begin
          triggered_o <= 1'b0;
          seq_a       <= 1'b0;
          tag_pend    <= 1'b0;
          ovf_o       <= 1'b0;
        end
      end else begin
        if (armed_o && fire_ok) begin
          armed_o     <= 1'b0;
          triggered_o <= 1'b1;
          if (tag_sel) tag_pend <= 1'b1;
          else         brk_o    <= 1'b1;
        end
        if (armed_o && a_hit && (mode == MODE_A_THEN_B || mode == MODE_A_EVT_B))
          seq_a <= 1'b1;
        if (tag_pend && exec_i) begin
          brk_o    <= 1'b1;
          tag_pend <= 1'b0;
        end
        if (push_req && fifo_full) ovf_o <= 1'b1;
      end
    end
  end

  AST_DISARM_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && fire_ok && !ctrl_wr) |=> (!armed_o && triggered_o)); // R10
  AST_FORCE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && fire_ok && !tag_sel && !ctrl_wr) |=> brk_o); // R11
  AST_TAG_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && fire_ok && tag_sel && !ctrl_wr && !tag_pend) |=> !brk_o); // R12
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !arm_wr) |=> ovf_o); // R9
  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !rd_i && !arm_wr) |=> $stable(fifo_cnt_o)); // R10
  AST_BRK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && !tag_pend) |=> !brk_o); // R11
endmodule

// File: tb/test_dbg_trig_top.sv
module test_dbg_trig_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, rnw = 0, fetch = 0, cof = 0, valid = 0, exec_p = 0, rd = 0;
  logic [1:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, addr = 0, rd_data;
  logic [7:0]  data = 0;
  logic [3:0]  cnt;
  logic        armed, trig, ovf, brk;
  int          n_vec = 0, n_err = 0;
  bit          done = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  dbg_trig_top i_dbg_trig_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .bus_valid_i(valid), .bus_addr_i(addr), .bus_data_i(data),
    .bus_rnw_i(rnw), .bus_fetch_i(fetch), .bus_cof_i(cof), .exec_i(exec_p), .rd_i(rd),
    .rd_data_o(rd_data), .fifo_cnt_o(cnt), .armed_o(armed), .triggered_o(trig),
    .ovf_o(ovf), .brk_o(brk));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] a, logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // ctrl: mode[3:0] tag[4] a_rw_en[5] a_rw[6] b_rw_en[7] b_rw[8] arm[9]
  task automatic arm(logic [3:0] m, logic tag = 0, logic aen = 0, logic arw = 0);
    cfg(2, {6'd0, 1'b1, 2'b00, arw, aen, tag, m});
    exp_q.delete();
  endtask

  task automatic bus(logic [15:0] a, logic [7:0] d = 0, logic r = 1, logic f = 0, logic c = 0);
    valid = 1; addr = a; data = d; rnw = r; fetch = f; cof = c;
    @(negedge clk); valid = 0; fetch = 0; cof = 0;
  endtask

  task automatic exp_push(logic [15:0] v);
    exp_q.push_back(v);
  endtask

  // monitor side of the scoreboard: pops the design's FIFO against the queue
  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      chk(req, rd_data, exp_q.pop_front());
      rd = 1; @(negedge clk); rd = 0;
    end
    chk({req, " empty"}, {cnt, rd_data}, 20'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {armed, trig, ovf, brk, cnt}, 8'h0);

    // R3 R8 R10 R11: A-only force, cof capture
    cfg(0, 16'h1234);
    cfg(3, 16'h1000);   // R2 ignored register
    arm(0);
    chk("R2 armed", armed, 1);
    bus(16'h1000, 0, 1, 0, 1); exp_push(16'h1000);
    chk("R11 no brk", brk, 0);
    bus(16'h1234, 0, 1, 0, 1); exp_push(16'h1234);
    chk("R11 brk", {brk, trig, armed}, 3'b110);
    bus(16'h2000, 0, 1, 0, 1);
    chk("R11 brk one cycle", brk, 0);
    chk("R10 no capture after fire", cnt, 2);
    drain("R8");

    // R3 A or B with direction check on A (write only)
    cfg(0, 16'h0010); cfg(1, 16'h0020);
    arm(1, 0, 1, 0);
    bus(16'h0010, 0, 1);
    chk("R3 rw-disqualified", trig, 0);
    bus(16'h0010, 0, 0);
    chk("R3 A write", trig, 1);
    arm(1, 0, 1, 0);
    bus(16'h0020, 0, 1);
    chk("R3 B", trig, 1);

    // R4 sequence
    cfg(0, 16'h0030); cfg(1, 16'h0040);
    arm(2);
    bus(16'h0040); chk("R4 B before A", trig, 0);
    bus(16'h0030); chk("R4 A only", trig, 0);
    bus(16'h0040); chk("R4 A then B", trig, 1);
    cfg(0, 16'h0050); cfg(1, 16'h0050);
    arm(2);
    bus(16'h0050); chk("R4 same cycle", trig, 0);
    bus(16'h0050); chk("R4 second", trig, 1);

    // R5 data-qualified
    cfg(0, 16'h0060); cfg(1, 16'h005A);
    arm(3);
    bus(16'h0060, 8'h11); chk("R5 eq miss", trig, 0);
    bus(16'h0060, 8'h5A); chk("R5 eq hit", trig, 1);
    arm(4);
    bus(16'h0060, 8'h5A); chk("R5 ne miss", trig, 0);
    bus(16'h0060, 8'h11); chk("R5 ne hit", trig, 1);

    // R6 ranges
    cfg(0, 16'h0100); cfg(1, 16'h01FF);
    arm(7); bus(16'h00FF); chk("R6 below", trig, 0);
    bus(16'h0100); chk("R6 low bound", trig, 1);
    arm(7); bus(16'h0200); chk("R6 above", trig, 0);
    bus(16'h01FF); chk("R6 high bound", trig, 1);
    arm(8); bus(16'h0150); chk("R6 out inside", trig, 0);
    bus(16'h0200); chk("R6 out above", trig, 1);
    arm(8); bus(16'h00FF); chk("R6 out below", trig, 1);

    // R7 events
    cfg(0, 16'h0090); cfg(1, 16'h0070);
    arm(5);
    bus(16'h0070, 8'hAB, 1, 0, 1); exp_push(16'h00AB);
    bus(16'h0071, 8'h99);
    bus(16'h0080, 8'h00, 1, 0, 1);
    bus(16'h0070, 8'hCD); exp_push(16'h00CD);
    chk("R7 no fire", {trig, armed}, 2'b01);
    drain("R7 evt");
    arm(6);
    bus(16'h0070, 8'h01);
    bus(16'h0090);
    bus(16'h0070, 8'h02); exp_push(16'h0002);
    drain("R7 A then evt");

    // R9 overflow
    cfg(0, 16'hFFFF);
    arm(0);
    for (int i = 0; i < 10; i++) begin
      bus(16'h0A00 + 16'(i), 0, 1, 0, 1);
      if (i < 8) exp_push(16'h0A00 + 16'(i));
    end
    chk("R9 full count", {ovf, cnt}, {1'b1, 4'd8});
    rd = 1; @(negedge clk); rd = 0;
    chk("R9 pop decrement", cnt, 7);
    chk("R9 ovf sticky", ovf, 1);
    void'(exp_q.pop_front());
    drain("R9 order");
    arm(0);
    chk("R2 arm clears", {ovf, cnt}, 5'h0);

    // R12 tag
    cfg(0, 16'h0300);
    arm(0, 1);
    bus(16'h0300, 0, 1, 0); chk("R12 data access", trig, 0);
    bus(16'h0300, 0, 1, 1); chk("R12 fetch fire", {trig, brk}, 2'b10);
    @(negedge clk); chk("R12 waits", brk, 0);
    exec_p = 1; @(negedge clk); exec_p = 0;
    chk("R12 brk on exec", brk, 1);
    @(negedge clk); chk("R12 pulse", brk, 0);

    // R13 disabled
    cfg(0, 16'h0400);
    arm(4'd9);
    bus(16'h0400, 0, 1, 1, 1);
    chk("R13 disabled", {trig, cnt}, 5'h0);

    // R2 arm=0 disarms
    cfg(2, 16'h0000);
    chk("R2 disarm", armed, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule